// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block makes the timing strobes for a serial port. The module clock first passes through an integer prescaler. The prescaler ratio comes from a 3-bit field of a control word. Each prescaler strobe then feeds a fractional stage, which scales the strobe rate by (step+1)/(span+1). The step and span registers are each 16 bits wide and each holds its value minus one. The fractional stage emits `tick16`, the 16x oversampling strobe that a transmitter and a receiver sample on. One bit period later it also emits `bit_tick`, once for every sixteen `tick16` pulses. The bit rate is therefore (prescaled clock / 16) x (step+1)/(span+1).

A second counter also runs on the prescaler strobes. It pulses `ms_tick` once every `ms_val` strobes, so `ms_val` is loaded with the number of prescaled clocks in one millisecond. A small state machine sequences the block:
- GEN_IDLE: everything is held clear while `en` is low.
- GEN_RUN: the generator counts.
- GEN_RELOAD: one clearing cycle follows a `rate_load` strobe, so that new settings start from a clean phase.

The transitions are:
- IDLE->RUN on `en`.
- RUN->IDLE when `en` drops.
- RUN->RELOAD on `rate_load`.
- RELOAD->RUN when `en` is high and `rate_load` is low.
- RELOAD->IDLE when `en` drops.
- RELOAD->RELOAD while `rate_load` stays high.

Top module: `baud_tick_gen`

## Requirements
- R1: While reset is asserted, and after reset while `en` stays low, `tick16`, `bit_tick` and `ms_tick` are all 0.
- R2: While `en` is low, no output pulses, whatever the rate registers hold and even when `rate_load` is strobed.
- R3: The prescaler ratio N comes from `ctrl_word[9:7]`. Code 6 gives N=7 and code 7 gives N=1. Any other code c gives N=6-c. Say `en` is first sampled high at clock edge E. Then prescaler strobes fall in the cycles E+kN-1 for k=1,2,...
- R4: With a=`incr_val`+1 and m=`mod_val`+1, the k-th prescaler strobe produces a one-cycle `tick16` in cycle E+kN exactly when floor(k*a/m) > floor((k-1)*a/m).
- R5: When `incr_val` >= `mod_val`, every prescaler strobe produces a `tick16`.
- R6: `bit_tick` pulses together with the 16th, 32nd, ... `tick16` counted since the generator last started. It never pulses without `tick16`.
- R7: `ms_tick` pulses in cycle E+kN whenever k is a multiple of M. M equals `ms_val`, and a value of 0 is treated as 1.
- R8: A `rate_load` strobe in cycle c during running suppresses the prescaler strobe in cycle c, clears all counters in cycle c+1, and restarts with the current settings as if E were c+2. No output pulses in cycles c+1 and c+2.
- R9: The control-word bits other than [9:7] have no effect on any output.
- R10: When `en` is sampled low, strobing stops from that edge. A pulse caused by the strobe in the last running cycle still appears one cycle later, and nothing appears after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low holds the generator cleared |
| rate_load | input | 1 | One-cycle strobe marking a write of any rate register |
| ctrl_word | input | 16 | Control word; bits [9:7] select the prescaler ratio |
| incr_val | input | 16 | Fractional step, stored minus one |
| mod_val | input | 16 | Fractional span, stored minus one |
| ms_val | input | 16 | Prescaled clocks per millisecond |
| tick16 | output | 1 | 16x oversampling strobe |
| bit_tick | output | 1 | Bit-period strobe, every 16th `tick16` |
| ms_tick | output | 1 | One-millisecond strobe |

## Verification
`tick16` and `ms_tick` hang off the same prescaler strobe, so they can pulse in the same cycle, and `bit_tick` can join them. The scoreboard provokes this with short millisecond counts (1 to 7) next to fraction ratios that tick on most strobes. It judges each cycle in which any output is expected or seen as one triple of all three outputs against the value predicted from R4, R6 and R7. A reload strobe that lands right after a strobe cycle is also covered: its already-registered pulse must still appear, and the two cycles after it must stay silent.

// File: rtl/baudgen_pkg.sv
package baudgen_pkg;

    typedef enum logic [1:0] {
        GEN_IDLE   = 2'd0,
        GEN_RUN    = 2'd1,
        GEN_RELOAD = 2'd2
    } gen_state_e;

    localparam int PRESCALE_CODE_W = 3;

    // Code 6 selects the largest ratio, code 7 aliases code 5, the rest count down from 6.
    function automatic logic [PRESCALE_CODE_W-1:0] prescale_ratio(
        input logic [PRESCALE_CODE_W-1:0] code
    );
        logic [PRESCALE_CODE_W-1:0] r;
        unique case (code)
            3'd6:    r = 3'd7;
            3'd7:    r = 3'd1;
            default: r = 3'd6 - code;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/bg_prescaler.sv
module bg_prescaler
    import baudgen_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       run,
    input  logic                       clr,
    input  logic [PRESCALE_CODE_W-1:0] code,
    output logic                       ref_en
);

    logic [PRESCALE_CODE_W-1:0] cnt_q;
    logic [PRESCALE_CODE_W-1:0] ratio;
    logic                       at_end;

    assign ratio  = prescale_ratio(code);
    assign at_end = (cnt_q >= ratio - 3'd1);
    assign ref_en = run & at_end;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= at_end ? '0 : cnt_q + 3'd1;
        end
    end

endmodule

// File: rtl/bg_fracmod.sv
module bg_fracmod #(
    parameter int RATE_W = 16,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              ref_en,
    input  logic [RATE_W-1:0] incr,
    input  logic [RATE_W-1:0] modu,
    output logic              tick,
    output logic              sub_tick
);

    localparam int ACC_W = RATE_W + 1;
    localparam int SUM_W = RATE_W + 2;
    localparam int OVS_W = (OVS > 2) ? $clog2(OVS) : 1;

    logic [ACC_W-1:0] step, span, acc_q;
    logic [SUM_W-1:0] sum, rem;
    logic             wrap;
    logic [OVS_W-1:0] ovs_q;
    logic             ovs_last;
    logic             tick_q, sub_q;

    assign step     = ACC_W'(incr) + ACC_W'(1);
    assign span     = ACC_W'(modu) + ACC_W'(1);
    assign sum      = SUM_W'(acc_q) + SUM_W'(step);
    assign wrap     = (sum >= SUM_W'(span));
    assign rem      = sum - SUM_W'(span);
    assign ovs_last = (ovs_q == OVS_W'(OVS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (clr) begin
            acc_q <= '0;
        end else if (ref_en) begin
            if (wrap) begin
                // a residue still at or above the span means step >= span: restart so every strobe wraps
                acc_q <= (rem >= SUM_W'(span)) ? '0 : rem[ACC_W-1:0];
            end else begin
                acc_q <= sum[ACC_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovs_q <= '0;
        end else if (clr) begin
            ovs_q <= '0;
        end else if (ref_en && wrap) begin
            ovs_q <= ovs_last ? '0 : ovs_q + OVS_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_q <= 1'b0;
            sub_q  <= 1'b0;
        end else begin
            tick_q <= ref_en & wrap;
            sub_q  <= ref_en & wrap & ovs_last;
        end
    end

    assign tick     = tick_q;
    assign sub_tick = sub_q;

endmodule

// File: rtl/bg_mstimer.sv
module bg_mstimer #(
    parameter int MS_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            ref_en,
    input  logic [MS_W-1:0] limit,
    output logic            ms_tick
);

    logic [MS_W-1:0] cnt_q;
    logic [MS_W-1:0] lim;
    logic            hit;
    logic            ms_q;

    assign lim = (limit == '0) ? MS_W'(1) : limit;
    assign hit = (cnt_q >= lim - MS_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ms_q  <= 1'b0;
        end else begin
            ms_q <= ref_en & hit;
            if (clr) begin
                cnt_q <= '0;
            end else if (ref_en) begin
                cnt_q <= hit ? '0 : cnt_q + MS_W'(1);
            end
        end
    end

    assign ms_tick = ms_q;

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
    import baudgen_pkg::*;
#(
    parameter int RATE_W  = 16,
    parameter int CTRL_W  = 16,
    parameter int DIV_LSB = 7,
    parameter int MS_W    = 16,
    parameter int OVS     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              rate_load,
    input  logic [CTRL_W-1:0] ctrl_word,
    input  logic [RATE_W-1:0] incr_val,
    input  logic [RATE_W-1:0] mod_val,
    input  logic [MS_W-1:0]   ms_val,
    output logic              tick16,
    output logic              bit_tick,
    output logic              ms_tick
);

    localparam int DIV_MSB = DIV_LSB + PRESCALE_CODE_W - 1;

    gen_state_e state_q, state_d;
    logic       run, clr;
    logic       ref_en;
    logic [PRESCALE_CODE_W-1:0] div_code;
    logic       ctrl_unused;

    assign div_code    = ctrl_word[DIV_MSB:DIV_LSB];
    assign ctrl_unused = ^{ctrl_word[CTRL_W-1:DIV_MSB+1], ctrl_word[DIV_LSB-1:0]};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= GEN_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GEN_IDLE: begin
                if (en) state_d = GEN_RUN;
            end
            GEN_RUN: begin
                if (!en)           state_d = GEN_IDLE;
                else if (rate_load) state_d = GEN_RELOAD;
            end
            GEN_RELOAD: begin
                if (!en)           state_d = GEN_IDLE;
                else if (!rate_load) state_d = GEN_RUN;
            end
            default: state_d = GEN_IDLE;
        endcase
    end

    // state outputs: a load cycle freezes counting, idle and reload clear
    always_comb begin
        run = 1'b0;
        clr = 1'b1;
        unique case (state_q)
            GEN_IDLE: begin
                run = 1'b0;
                clr = 1'b1;
            end
            GEN_RUN: begin
                run = ~rate_load;
                clr = 1'b0;
            end
            GEN_RELOAD: begin
                run = 1'b0;
                clr = 1'b1;
            end
            default: begin
                run = 1'b0;
                clr = 1'b1;
            end
        endcase
    end

    bg_prescaler u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .clr    (clr),
        .code   (div_code),
        .ref_en (ref_en)
    );

    bg_fracmod #(
        .RATE_W (RATE_W),
        .OVS    (OVS)
    ) u_frac (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .ref_en   (ref_en),
        .incr     (incr_val),
        .modu     (mod_val),
        .tick     (tick16),
        .sub_tick (bit_tick)
    );

    bg_mstimer #(
        .MS_W (MS_W)
    ) u_ms (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .ref_en  (ref_en),
        .limit   (ms_val),
        .ms_tick (ms_tick)
    );

endmodule

// File: rtl/bg_checker.sv
module bg_checker
    import baudgen_pkg::*;
(
    input logic                       clk,
    input logic                       rst_n,
    input logic                       en,
    input logic                       rate_load,
    input logic                       run,
    input logic                       clr,
    input logic                       ref_en,
    input logic [PRESCALE_CODE_W-1:0] div_code,
    input logic                       tick16,
    input logic                       bit_tick,
    input logic                       ms_tick
);

    logic [1:0]                 age_q;
    logic [PRESCALE_CODE_W-1:0] gap_q;
    logic                       seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q <= '0;
        end else if (age_q != 2'd3) begin
            age_q <= age_q + 2'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (clr) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (run) begin
            if (ref_en) begin
                gap_q  <= '0;
                seen_q <= 1'b1;
            end else begin
                gap_q <= gap_q + 3'd1;
            end
        end
    end

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3 && !$past(en) && !$past(en, 2)) |-> (!tick16 && !bit_tick && !ms_tick));

    assert_strobe_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && ref_en && seen_q) |-> ({1'b0, gap_q} + 4'd1 == {1'b0, prescale_ratio(div_code)}));

    assert_tick_follows_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tick16 |-> $past(ref_en));

    assert_bit_within_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> tick16);

    assert_ms_follows_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ms_tick |-> $past(ref_en));

    assert_load_silence_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rate_load |=> (!tick16 && !ms_tick));

endmodule

bind baud_tick_gen bg_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .rate_load (rate_load),
    .run       (run),
    .clr       (clr),
    .ref_en    (ref_en),
    .div_code  (div_code),
    .tick16    (tick16),
    .bit_tick  (bit_tick),
    .ms_tick   (ms_tick)
);

// File: tb/sim_baud_tick_gen.sv
module sim_baud_tick_gen;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        rate_load = 1'b0;
    logic [15:0] ctrl_word = '0;
    logic [15:0] incr_val = '0;
    logic [15:0] mod_val = '0;
    logic [15:0] ms_val = '0;
    logic        tick16, bit_tick, ms_tick;

    always #(CLK_PERIOD / 2) clk = ~clk;

    baud_tick_gen u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .rate_load (rate_load),
        .ctrl_word (ctrl_word),
        .incr_val  (incr_val),
        .mod_val   (mod_val),
        .ms_val    (ms_val),
        .tick16    (tick16),
        .bit_tick  (bit_tick),
        .ms_tick   (ms_tick)
    );

    typedef struct {
        int    at;
        bit    t;
        bit    b;
        bit    m;
        string req;
    } exp_t;

    exp_t  sb[$];
    int    cyc = 0;
    int    vectors = 0;
    int    miscompares = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int ratio_of(int code);
        if (code == 6) return 7;
        if (code == 7) return 1;
        return 6 - code;
    endfunction

    // expected events of one running stretch: R4 fraction, R6 every 16th tick, R7 every M-th strobe
    function automatic void push_events(int e, int code, int inc, int md, int msn, int len, string req);
        int n;
        int a;
        int m;
        int mm;
        int tcount;
        n = ratio_of(code);
        a = inc + 1;
        m = md + 1;
        mm = (msn == 0) ? 1 : msn;
        tcount = 0;
        for (int k = 1; k * n <= len; k++) begin
            longint hi;
            longint lo;
            bit     w;
            bit     b;
            bit     s;
            exp_t   x;
            hi = (longint'(k) * a) / m;
            lo = (longint'(k - 1) * a) / m;
            w = (hi != lo);
            if (w) tcount++;
            b = w && (tcount % 16 == 0);
            s = (k % mm) == 0;
            if (w || s) begin
                x.at = e + k * n;
                x.t = w;
                x.b = b;
                x.m = s;
                x.req = req;
                sb.push_back(x);
            end
        end
    endfunction

    // monitor: pops expected triples and compares them with the outputs
    always @(negedge clk) begin
        if (rst_n) begin
            while (sb.size() > 0 && sb[0].at < cyc) begin
                vectors++;
                miscompares++;
                $display("FAIL %s: cycle %0d got nothing, expected tick/bit/ms %0b%0b%0b",
                         sb[0].req, sb[0].at, sb[0].t, sb[0].b, sb[0].m);
                sb.delete(0);
            end
            if (sb.size() > 0 && sb[0].at == cyc) begin
                vectors++;
                if ({tick16, bit_tick, ms_tick} !== {sb[0].t, sb[0].b, sb[0].m}) begin
                    miscompares++;
                    $display("FAIL %s: cycle %0d tick/bit/ms %b%b%b, expected %0b%0b%0b",
                             sb[0].req, cyc, tick16, bit_tick, ms_tick, sb[0].t, sb[0].b, sb[0].m);
                end
                sb.delete(0);
            end else if (tick16 || bit_tick || ms_tick) begin
                vectors++;
                miscompares++;
                $display("FAIL %s: cycle %0d tick/bit/ms %b%b%b, expected 000",
                         cur_req, cyc, tick16, bit_tick, ms_tick);
            end
        end
    end

    task automatic set_cfg(int code, int extra, int inc, int md, int msn);
        ctrl_word = 16'((code << 7) | extra);
        incr_val  = 16'(inc);
        mod_val   = 16'(md);
        ms_val    = 16'(msn);
    endtask

    task automatic drain(string req);
        repeat (6) @(negedge clk);
        vectors++;
        if (sb.size() != 0) begin
            miscompares++;
            $display("FAIL %s: %0d expected events left, expected 0", req, sb.size());
            sb.delete();
        end
    endtask

    task automatic run_case(string req, int code, int extra, int inc, int md, int msn, int len);
        int e;
        @(negedge clk);
        cur_req = req;
        set_cfg(code, extra, inc, md, msn);
        en = 1'b1;
        e = cyc + 1;
        push_events(e, code, inc, md, msn, len, req);
        repeat (len) @(negedge clk);
        en = 1'b0;       // R10: events up to one cycle after the last running cycle only
        drain(req);
    endtask

    task automatic reload_case(int len1, int len2);
        int e;
        @(negedge clk);
        cur_req = "R8";
        set_cfg(2, 0, 1, 2, 7);
        en = 1'b1;
        e = cyc + 1;
        push_events(e, 2, 1, 2, 7, len1 - 1, "R8");
        repeat (len1) @(negedge clk);
        set_cfg(4, 0, 0, 0, 3);
        rate_load = 1'b1;
        push_events(cyc + 2, 4, 0, 0, 3, len2, "R8");
        @(negedge clk);
        rate_load = 1'b0;
        repeat (len2) @(negedge clk);
        en = 1'b0;
        drain("R8");
    endtask

    task automatic idle_case();
        bit bad;
        bad = 1'b0;
        @(negedge clk);
        cur_req = "R2";
        set_cfg(5, 0, 0, 0, 1);
        en = 1'b0;
        for (int i = 0; i < 30; i++) begin
            rate_load = (i % 7 == 3);
            @(negedge clk);
            if (tick16 || bit_tick || ms_tick) bad = 1'b1;
        end
        rate_load = 1'b0;
        vectors++;
        if (bad) begin
            miscompares++;
            $display("FAIL R2: pulse seen while disabled, got 1 expected 0");
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        vectors++;
        if ({tick16, bit_tick, ms_tick} !== 3'b000) begin
            miscompares++;
            $display("FAIL R1: outputs %b%b%b in reset, expected 000", tick16, bit_tick, ms_tick);
        end
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        vectors++;
        if ({tick16, bit_tick, ms_tick} !== 3'b000) begin
            miscompares++;
            $display("FAIL R1: outputs %b%b%b after reset, expected 000", tick16, bit_tick, ms_tick);
        end
        idle_case();
        // R3: ratio 1 from code 5, every strobe ticks, R6 bit ticks at 16 and 32
        run_case("R3", 5, 0, 0, 0, 4, 40);
        // R3: code 7 aliases ratio 1
        run_case("R3", 7, 0, 0, 2, 5, 120);
        // R9: code 6 (ratio 7) with trigger fields set, fraction 3/5
        run_case("R9", 6, (16'h2A << 10) | 16'h15, 2, 4, 3, 300);
        // R7: ms count 0 treated as 1, ratio 6, fraction 7/10
        run_case("R7", 0, 0, 6, 9, 0, 400);
        // R5: step above span ticks on every strobe, ratio 3
        run_case("R5", 3, 0, 5, 2, 2, 100);
        // R4: wide span, sparse ticks, ratio 1
        run_case("R4", 5, 0, 999, 65535, 64, 2000);
        // R6: ratio 2, half-rate fraction, several bit periods
        run_case("R6", 4, 0, 0, 1, 9, 200);
        reload_case(50, 60);
        idle_case();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: run did not finish, got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule